// File: doc/BRIEF.md
# Dual I/O Window Address Decoder

This block sits between a host I/O bus and a removable-card socket and decides, for every host I/O cycle, whether the address falls inside one of two programmable card I/O windows. Each window is bounded by a 16-bit base and an inclusive 16-bit limit. Both windows keep their transfer options in one shared option byte, one nybble per window. A separate enable byte holds one enable bit per window. A hit reports the window number, whether the transfer is 16 bits wide, and the wait-state options of that window.

Software can reach every register byte by byte through a flat register port. It can also issue one-cycle map and unmap commands. A map command writes base and limit, merges the new option nybble into the shared option byte without touching the other window's nybble, and sets the enable. An unmap command clears the enable and zeroes the bounds. A command that names a window number other than 0 or 1 is refused.

Top module: `iowin_decoder`

## Requirements
- R1: After a synchronous reset every register reads zero and `hit`, `hit_win`, `bus16`, `zero_wait`, `extra_wait` and `cmd_reject` are low.
- R2: Byte register map (4-bit address): window w occupies offsets 4w..4w+3 as base low, base high, limit low, limit high. Offset 8 is the option byte: window 0 in bits 3:0, window 1 in bits 7:4. Offset 9 holds the enables in bits 1:0, bit w for window w. Offsets 10 to 15 read zero and ignore writes. `reg_rd_data` shows the addressed register in the same cycle, and a write takes effect at the clock edge.
- R3: A window matches when its enable bit is set and base <= `host_addr` <= limit, compared unsigned. Outputs are registered and show the result of the `host_valid` cycle one clock later. `host_valid` low gives no hit.
- R4: When both windows match, window 0 is reported.
- R5: Option nybble bit 0 is zero-wait and bit 1 is extra-wait; on a hit they appear on `zero_wait` and `extra_wait`.
- R6: Option nybble bit 2 means the card signals its own width: `bus16` then follows `card_is16`. Otherwise `bus16` equals nybble bit 3, the 16-bit data flag.
- R7: A map command (`cmd_map`=1) for window w sets base = `cmd_start` and limit = `cmd_start + cmd_size - 1` (modulo 2^16). It replaces only window w's option nybble with `cmd_opts` and sets enable bit w, all visible after the next edge.
- R8: An unmap command for window w clears enable bit w and zeroes its base and limit. Both option nybbles are left unchanged.
- R9: A command with `cmd_win` of 2 or 3 changes no register and raises `cmd_reject` for one cycle after the edge.
- R10: A command and a byte write in the same cycle: the command is applied and the byte write is dropped.
- R11: On a miss, `hit_win`, `bus16`, `zero_wait` and `extra_wait` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Byte register write strobe |
| reg_wr_addr | input | 4 | Byte register write offset |
| reg_wr_data | input | 8 | Byte register write data |
| reg_rd_addr | input | 4 | Byte register read offset |
| reg_rd_data | output | 8 | Read data for `reg_rd_addr` |
| cmd_valid | input | 1 | Window command strobe |
| cmd_win | input | 2 | Window number for the command |
| cmd_map | input | 1 | 1 = map, 0 = unmap |
| cmd_start | input | 16 | Window base for a map |
| cmd_size | input | 16 | Window size in bytes for a map (non-zero) |
| cmd_opts | input | 4 | Option nybble for a map |
| cmd_reject | output | 1 | Pulses when a command named an absent window |
| host_valid | input | 1 | Host I/O cycle present |
| host_addr | input | 16 | Host I/O address |
| card_is16 | input | 1 | Card reports a 16-bit access |
| hit | output | 1 | Address fell in an enabled window |
| hit_win | output | 1 | Window that matched |
| bus16 | output | 1 | Transfer is 16 bits wide |
| zero_wait | output | 1 | Zero-wait option of the matched window |
| extra_wait | output | 1 | Extra-wait option of the matched window |

## Verification
The assertions assume a map command always carries a non-zero size. They also assume `cmd_win` and the host inputs are driven to known values whenever their strobes are high, so that the window index taken from the previous cycle is meaningful. The random stimulus draws sizes from 1 upward and never leaves a strobe input undriven. Probe addresses are biased toward each window's base, limit and the addresses just outside them, so that overlap, inverted bounds written by raw byte writes, and wrap to 0xFFFF are all reached.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

    localparam int NWIN    = 2;
    localparam int RA_W    = 4;
    localparam int OPT_W   = 4;
    localparam logic [RA_W-1:0] RA_OPT = 4'h8;
    localparam logic [RA_W-1:0] RA_EN  = 4'h9;

    // One window's option nybble, bit 3 down to bit 0.
    typedef struct packed {
        logic data16;
        logic cs16;
        logic extra_ws;
        logic zero_ws;
    } win_opt_t;

    typedef struct packed {
        logic hit;
        logic idx;
        logic width16;
        logic zero_ws;
        logic extra_ws;
    } dec_res_t;

    function automatic logic pick_width(win_opt_t o, logic card16);
        return o.cs16 ? card16 : o.data16;
    endfunction

    function automatic logic [2*OPT_W-1:0] merge_opt(logic [2*OPT_W-1:0] cur,
                                                    logic win,
                                                    logic [OPT_W-1:0] nyb);
        return win ? {nyb, cur[OPT_W-1:0]} : {cur[2*OPT_W-1:OPT_W], nyb};
    endfunction

endpackage

// File: rtl/iowin_regs.sv
module iowin_regs
    import iowin_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [RA_W-1:0]       wr_addr,
    input  logic [7:0]            wr_data,
    input  logic [RA_W-1:0]       rd_addr,
    output logic [7:0]            rd_data,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_win,
    input  logic                  cmd_map,
    input  logic [AW-1:0]         cmd_start,
    input  logic [AW-1:0]         cmd_size,
    input  logic [OPT_W-1:0]      cmd_opts,
    output logic                  cmd_reject,
    output logic [NWIN*AW-1:0]    base_o,
    output logic [NWIN*AW-1:0]    limit_o,
    output logic [2*OPT_W-1:0]    opt_o,
    output logic [NWIN-1:0]       en_o
);

    logic [AW-1:0]      base_q  [NWIN];
    logic [AW-1:0]      limit_q [NWIN];
    logic [2*OPT_W-1:0] opt_q;
    logic [NWIN-1:0]    en_q;
    logic               cmd_bad;
    logic               cw;

    assign cmd_bad = (cmd_win > 2'd1);
    assign cw      = cmd_win[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NWIN; w++) begin
                base_q[w]  <= '0;
                limit_q[w] <= '0;
            end
            opt_q      <= '0;
            en_q       <= '0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_reject <= 1'b0;
            if (cmd_valid) begin
                if (cmd_bad) begin
                    cmd_reject <= 1'b1;
                end else if (cmd_map) begin
                    base_q[cw]  <= cmd_start;
                    limit_q[cw] <= cmd_start + cmd_size - AW'(1);
                    opt_q       <= merge_opt(opt_q, cw, cmd_opts);
                    en_q[cw]    <= 1'b1;
                end else begin
                    base_q[cw]  <= '0;
                    limit_q[cw] <= '0;
                    en_q[cw]    <= 1'b0;
                end
            end else if (wr_en) begin
                if (!wr_addr[3]) begin
                    case (wr_addr[1:0])
                        2'd0: base_q[wr_addr[2]][7:0]     <= wr_data;
                        2'd1: base_q[wr_addr[2]][AW-1:8]  <= wr_data[AW-9:0];
                        2'd2: limit_q[wr_addr[2]][7:0]    <= wr_data;
                        default: limit_q[wr_addr[2]][AW-1:8] <= wr_data[AW-9:0];
                    endcase
                end else if (wr_addr == RA_OPT) begin
                    opt_q <= wr_data;
                end else if (wr_addr == RA_EN) begin
                    en_q <= wr_data[NWIN-1:0];
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (!rd_addr[3]) begin
            case (rd_addr[1:0])
                2'd0: rd_data = base_q[rd_addr[2]][7:0];
                2'd1: rd_data = 8'(base_q[rd_addr[2]][AW-1:8]);
                2'd2: rd_data = limit_q[rd_addr[2]][7:0];
                default: rd_data = 8'(limit_q[rd_addr[2]][AW-1:8]);
            endcase
        end else if (rd_addr == RA_OPT) begin
            rd_data = opt_q;
        end else if (rd_addr == RA_EN) begin
            rd_data = 8'(en_q);
        end
    end

    for (genvar g = 0; g < NWIN; g++) begin : g_flat
        assign base_o[g*AW +: AW]  = base_q[g];
        assign limit_o[g*AW +: AW] = limit_q[g];
    end
    assign opt_o = opt_q;
    assign en_o  = en_q;

    // R7: a map command leaves the window enabled
    a_r7_map_enables: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_win[1] && cmd_map) |=> en_q[$past(cw)]);

    // R7: mapping window 0 keeps window 1's nybble
    a_r7_keep_other_nybble: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_win == 2'd0 && cmd_map)
            |=> opt_q[2*OPT_W-1:OPT_W] == $past(opt_q[2*OPT_W-1:OPT_W]));

    // R8: unmap clears enable and base, options untouched
    a_r8_unmap_clears: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_win[1] && !cmd_map)
            |=> !en_q[$past(cw)] && base_q[$past(cw)] == '0 && $stable(opt_q));

    // R9: absent window refused with no register change
    a_r9_reject_no_change: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_win[1]) |=> cmd_reject && $stable(opt_q) && $stable(en_q));

endmodule

// File: rtl/iowin_match.sv
module iowin_match #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] limit,
    input  logic          en,
    output logic          match
);

    logic above_base;
    logic below_limit;

    assign above_base  = (addr >= base);
    assign below_limit = (addr <= limit);
    assign match       = en && above_base && below_limit;

endmodule

// File: rtl/iowin_select.sv
module iowin_select
    import iowin_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               host_valid,
    input  logic [NWIN-1:0]    match,
    input  logic [2*OPT_W-1:0] opt,
    input  logic               card16,
    output dec_res_t           res
);

    logic     sel;
    logic     any;
    win_opt_t o;
    dec_res_t nxt;

    assign sel = !match[0];
    assign any = host_valid && (|match);
    assign o   = sel ? win_opt_t'(opt[2*OPT_W-1:OPT_W]) : win_opt_t'(opt[OPT_W-1:0]);

    always_comb begin
        nxt = '0;
        if (any) begin
            nxt.hit      = 1'b1;
            nxt.idx      = sel;
            nxt.width16  = pick_width(o, card16);
            nxt.zero_ws  = o.zero_ws;
            nxt.extra_ws = o.extra_ws;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) res <= '0;
        else     res <= nxt;
    end

    // R4: window 0 wins when it matches
    a_r4_win0_priority: assert property (@(posedge clk) disable iff (rst)
        (host_valid && match[0]) |=> res.hit && !res.idx);

    // R3: no host cycle, no hit
    a_r3_idle_no_hit: assert property (@(posedge clk) disable iff (rst)
        !host_valid |=> !res.hit);

    // R3: a matching enabled window always yields a hit
    a_r3_match_hits: assert property (@(posedge clk) disable iff (rst)
        (host_valid && match[1]) |=> res.hit);

endmodule

// File: rtl/iowin_decoder.sv
module iowin_decoder
    import iowin_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr_en,
    input  logic [3:0]      reg_wr_addr,
    input  logic [7:0]      reg_wr_data,
    input  logic [3:0]      reg_rd_addr,
    output logic [7:0]      reg_rd_data,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_win,
    input  logic            cmd_map,
    input  logic [AW-1:0]   cmd_start,
    input  logic [AW-1:0]   cmd_size,
    input  logic [3:0]      cmd_opts,
    output logic            cmd_reject,
    input  logic            host_valid,
    input  logic [AW-1:0]   host_addr,
    input  logic            card_is16,
    output logic            hit,
    output logic            hit_win,
    output logic            bus16,
    output logic            zero_wait,
    output logic            extra_wait
);

    logic [NWIN*AW-1:0] base_w;
    logic [NWIN*AW-1:0] limit_w;
    logic [2*OPT_W-1:0] opt_w;
    logic [NWIN-1:0]    en_w;
    logic [NWIN-1:0]    match_w;
    dec_res_t           res_w;

    iowin_regs #(.AW(AW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr_en),
        .wr_addr    (reg_wr_addr),
        .wr_data    (reg_wr_data),
        .rd_addr    (reg_rd_addr),
        .rd_data    (reg_rd_data),
        .cmd_valid  (cmd_valid),
        .cmd_win    (cmd_win),
        .cmd_map    (cmd_map),
        .cmd_start  (cmd_start),
        .cmd_size   (cmd_size),
        .cmd_opts   (cmd_opts),
        .cmd_reject (cmd_reject),
        .base_o     (base_w),
        .limit_o    (limit_w),
        .opt_o      (opt_w),
        .en_o       (en_w)
    );

    for (genvar g = 0; g < NWIN; g++) begin : g_win
        iowin_match #(.AW(AW)) u_match (
            .addr  (host_addr),
            .base  (base_w[g*AW +: AW]),
            .limit (limit_w[g*AW +: AW]),
            .en    (en_w[g]),
            .match (match_w[g])
        );
    end

    iowin_select u_sel (
        .clk        (clk),
        .rst        (rst),
        .host_valid (host_valid),
        .match      (match_w),
        .opt        (opt_w),
        .card16     (card_is16),
        .res        (res_w)
    );

    assign hit        = res_w.hit;
    assign hit_win    = res_w.idx;
    assign bus16      = res_w.width16;
    assign zero_wait  = res_w.zero_ws;
    assign extra_wait = res_w.extra_ws;

    // R11: quiet outputs on a miss
    a_r11_miss_quiet: assert property (@(posedge clk) disable iff (rst)
        !hit |-> !(hit_win || bus16 || zero_wait || extra_wait));

endmodule

// File: tb/tb_iowin_decoder.sv
module tb_iowin_decoder;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_addr = '0;
    logic [7:0]  reg_wr_data = '0;
    logic [3:0]  reg_rd_addr = '0;
    logic [7:0]  reg_rd_data;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_win = '0;
    logic        cmd_map = 1'b0;
    logic [15:0] cmd_start = '0;
    logic [15:0] cmd_size = 16'd1;
    logic [3:0]  cmd_opts = '0;
    logic        cmd_reject;
    logic        host_valid = 1'b0;
    logic [15:0] host_addr = '0;
    logic        card_is16 = 1'b0;
    logic        hit, hit_win, bus16, zero_wait, extra_wait;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [15:0] m_base [2];
    logic [15:0] m_lim  [2];
    logic [7:0]  m_opt;
    logic [1:0]  m_en;

    always #(CLK_P/2) clk = ~clk;

    iowin_decoder dut (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .cmd_valid(cmd_valid), .cmd_win(cmd_win), .cmd_map(cmd_map),
        .cmd_start(cmd_start), .cmd_size(cmd_size), .cmd_opts(cmd_opts),
        .cmd_reject(cmd_reject),
        .host_valid(host_valid), .host_addr(host_addr), .card_is16(card_is16),
        .hit(hit), .hit_win(hit_win), .bus16(bus16),
        .zero_wait(zero_wait), .extra_wait(extra_wait)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_rd(logic [3:0] a);
        if (!a[3]) begin
            case (a[1:0])
                2'd0: return m_base[a[2]][7:0];
                2'd1: return m_base[a[2]][15:8];
                2'd2: return m_lim[a[2]][7:0];
                default: return m_lim[a[2]][15:8];
            endcase
        end
        if (a == 4'h8) return m_opt;
        if (a == 4'h9) return {6'd0, m_en};
        return 8'h00;
    endfunction

    // packed {hit, win, bus16, zero_wait, extra_wait}
    function automatic logic [4:0] model_dec(logic [15:0] a, logic c16);
        logic [3:0] o;
        for (int w = 0; w < 2; w++) begin
            if (m_en[w] && a >= m_base[w] && a <= m_lim[w]) begin
                o = w ? m_opt[7:4] : m_opt[3:0];
                return {1'b1, w[0], (o[2] ? c16 : o[3]), o[0], o[1]};
            end
        end
        return 5'b0;
    endfunction

    task automatic reg_write(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        if (!a[3]) begin
            case (a[1:0])
                2'd0: m_base[a[2]][7:0]  = d;
                2'd1: m_base[a[2]][15:8] = d;
                2'd2: m_lim[a[2]][7:0]   = d;
                default: m_lim[a[2]][15:8] = d;
            endcase
        end else if (a == 4'h8) m_opt = d;
        else if (a == 4'h9) m_en = d[1:0];
    endtask

    task automatic command(logic [1:0] w, logic mp, logic [15:0] st, logic [15:0] sz,
                           logic [3:0] op, logic with_wr, logic [3:0] wa, logic [7:0] wd);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_win = w; cmd_map = mp;
        cmd_start = st; cmd_size = sz; cmd_opts = op;
        reg_wr_en = with_wr; reg_wr_addr = wa; reg_wr_data = wd;
        @(negedge clk);
        cmd_valid = 1'b0; reg_wr_en = 1'b0;
        check("R9 reject flag", cmd_reject, w[1]);
        if (!w[1]) begin
            if (mp) begin
                m_base[w[0]] = st;
                m_lim[w[0]]  = st + sz - 16'd1;
                if (w[0]) m_opt[7:4] = op; else m_opt[3:0] = op;
                m_en[w[0]] = 1'b1;
            end else begin
                m_base[w[0]] = '0;
                m_lim[w[0]]  = '0;
                m_en[w[0]]   = 1'b0;
            end
        end
    endtask

    task automatic probe(string req, logic [15:0] a, logic c16);
        logic [4:0] e;
        @(negedge clk);
        host_valid = 1'b1; host_addr = a; card_is16 = c16;
        e = model_dec(a, c16);
        @(negedge clk);
        host_valid = 1'b0;
        check(req, {hit, hit_win, bus16, zero_wait, extra_wait}, e);
    endtask

    task automatic check_regs(string req);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk);
            reg_rd_addr = a[3:0];
            #1;
            check(req, reg_rd_data, model_rd(a[3:0]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] pa;
        void'($urandom(32'd24681));
        for (int w = 0; w < 2; w++) begin m_base[w] = '0; m_lim[w] = '0; end
        m_opt = '0; m_en = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #1;
        check("R1 outputs", {hit, hit_win, bus16, zero_wait, extra_wait, cmd_reject}, 6'b0);
        check_regs("R1 registers");
        probe("R1 no hit after reset", 16'h0000, 1'b1);

        // R7: map both windows, nybble merge
        command(2'd0, 1'b1, 16'h0300, 16'h0020, 4'b1000, 1'b0, 4'h0, 8'h00);
        command(2'd1, 1'b1, 16'h0310, 16'h0040, 4'b0111, 1'b0, 4'h0, 8'h00);
        check_regs("R7 map readback");
        probe("R4 overlap picks window 0", 16'h0310, 1'b0);
        probe("R6 data16 flag", 16'h0300, 1'b0);
        probe("R3 window 0 limit", 16'h031F, 1'b0);
        probe("R6 width from card", 16'h0320, 1'b1);
        probe("R5 wait options", 16'h0320, 1'b0);
        probe("R3 window 1 limit", 16'h034F, 1'b1);
        probe("R11 past limit", 16'h0350, 1'b1);
        probe("R11 below base", 16'h02FF, 1'b1);

        // R8: unmap keeps options
        command(2'd0, 1'b0, 16'h0000, 16'h0001, 4'h0, 1'b0, 4'h0, 8'h00);
        check_regs("R8 unmap readback");
        probe("R8 unmapped window", 16'h0300, 1'b0);

        // R9: absent window, with a byte write in the same cycle
        command(2'd2, 1'b1, 16'h1234, 16'h0010, 4'hF, 1'b1, 4'h9, 8'h00);
        command(2'd3, 1'b0, 16'h0000, 16'h0001, 4'h0, 1'b0, 4'h0, 8'h00);
        check_regs("R9 no register change");

        // R10: command beats byte write
        command(2'd0, 1'b1, 16'hFFF0, 16'h0010, 4'b0101, 1'b1, 4'h9, 8'h00);
        check_regs("R10 byte write dropped");
        probe("R3 top of space", 16'hFFFF, 1'b0);

        // R2: raw byte writes, unused offsets
        reg_write(4'hA, 8'h5A);
        reg_write(4'h4, 8'h00);
        reg_write(4'h5, 8'h20);
        reg_write(4'h6, 8'h00);
        reg_write(4'h7, 8'h10);
        check_regs("R2 byte map");
        probe("R3 inverted bounds miss", 16'h1800, 1'b0);

        // mixed random
        for (int i = 0; i < 600; i++) begin
            int r;
            int w;
            r = $urandom_range(0, 9);
            w = $urandom_range(0, 1);
            if (r < 2) begin
                reg_write(4'($urandom_range(0, 11)), 8'($urandom));
            end else if (r < 4) begin
                command(2'($urandom_range(0, 3)), 1'($urandom_range(0, 3) != 0),
                        16'($urandom), 16'($urandom_range(1, 2048)), 4'($urandom),
                        1'($urandom), 4'($urandom), 8'($urandom));
            end else if (r == 4) begin
                check_regs("R2 random readback");
            end else begin
                case ($urandom_range(0, 4))
                    0: pa = m_base[w];
                    1: pa = m_lim[w];
                    2: pa = m_base[w] - 16'd1;
                    3: pa = m_lim[w] + 16'd1;
                    default: pa = 16'($urandom);
                endcase
                probe("R3 R4 R5 R6 random decode", pa, 1'($urandom));
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule